// File: doc/BRIEF.md
# Speculative Load Tracking Table

This block lets a compiler hoist a load above stores that might write the same memory. When a hoisted (advanced) load issues, the block keeps its data address and its destination register number in a small fully associative table. Each later store presents its address to the table. Every tracked load whose address falls in the same aligned granule is marked poisoned, because the store may have changed the value that load already returned. A speculative load that would have faulted raises no exception. It is recorded as poisoned at once.

When the consumer reaches the point where the load used to be, it issues a check on the destination register. The check passes when the register is tracked and clean, and the speculative value is then used as it is. The check fails when the register is poisoned or no longer tracked. A failure raises a recovery request that names the register, and the recovery code reloads the value without speculation. That reload is the access that raises any real fault. Every check frees the entry it looked up. When the table is full, a new load displaces a victim picked by a rotating pointer, and a later check on the displaced register fails safely. A flush empties the table.

Top module: `spec_load_tracker`

## Requirements
- R1: After reset, or in the cycle after `flush_i` is high, no register is tracked, so every check fails with a recovery request. A check issued in the same cycle as a flush also fails.
- R2: A check on a register whose advanced load was recorded and has not been poisoned passes. `chk_done_o` and `chk_pass_o` are high in the cycle after `chk_valid_i`, and `recover_o` stays low.
- R3: A store poisons every tracked load whose address has the same bits above the granule offset (`GRAN_LSB`=3, so 8-byte granules). A store that only partly overlaps, for example at byte offset 4 of the granule, still hits. The check that follows fails, with `recover_o` high and `recover_dst_o` equal to the checked register.
- R4: A store to a different granule leaves a tracked load untouched, and its check passes.
- R5: An advanced load with `ld_fault_i` high is recorded as poisoned, so its check fails.
- R6: A check on a register that has no entry fails.
- R7: Every check, passing or failing, frees the entry of that register, so a second check on the same register fails.
- R8: An advanced load to a register that already has an entry overwrites that entry. The new address replaces the old one, the poison is cleared (unless the new load faults), and a store to the old address then has no effect.
- R9: A table of `ENTRIES`=16 entries fills the lowest free slot first. When the table is full, a new load replaces the slot named by a rotating pointer that starts at slot 0 after reset or flush and advances on each replacement. The displaced register's check fails and the other entries are kept.
- R10: If a store and an advanced load occur in the same cycle, the store is applied first, so the load recorded in that cycle is not poisoned by it.
- R11: If an advanced load and a check name the same register in the same cycle, the check sees the table as it was before the load, and the entry written by the load remains afterwards.
- R12: A store in the same cycle as a check is applied before the check, so a hit makes that check fail. `chk_done_o` pulses for exactly the cycle after each check and is low otherwise; when it is high, exactly one of `chk_pass_o` and `recover_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Empty the whole table |
| ld_valid_i | input | 1 | An advanced load is recorded this cycle |
| ld_addr_i | input | ADDR_W | Data address of the advanced load |
| ld_dst_i | input | REG_W | Destination register of the advanced load |
| ld_fault_i | input | 1 | The advanced load would have faulted |
| st_valid_i | input | 1 | A store is snooped this cycle |
| st_addr_i | input | ADDR_W | Address of the store |
| chk_valid_i | input | 1 | A check is issued this cycle |
| chk_dst_i | input | REG_W | Register being checked |
| chk_done_o | output | 1 | Check result is valid |
| chk_pass_o | output | 1 | Check passed; speculative value is usable |
| recover_o | output | 1 | Check failed; recovery reload required |
| recover_dst_o | output | REG_W | Register to reload (zero when no recovery) |

## Verification
The assertions assume a well-formed table, where at most one valid entry holds a given register. They also assume that the rotating victim pointer is only consulted when every slot is busy. Both conditions hold only if each port carries at most one operation per cycle, and the stimulus follows that rule. The bench drives each operation, or each deliberate same-cycle pair of operations, on the falling clock edge. It starts every table-full test from a flush, so the victim pointer is at a known slot.

// File: rtl/slt_pkg.sv
package slt_pkg;
   // Registered outcome of one check operation
   typedef enum logic [1:0] {
      CHK_IDLE    = 2'd0,
      CHK_PASS    = 2'd1,
      CHK_RECOVER = 2'd2
   } chk_res_e;
endpackage

// File: rtl/slt_match.sv
module slt_match #(
   parameter int N     = 16,
   parameter int TAG_W = 29,
   parameter int REG_W = 7
) (
   input  logic [N-1:0]             valid_i,
   input  logic [N-1:0][TAG_W-1:0]  tag_i,
   input  logic [N-1:0][REG_W-1:0]  dst_i,
   input  logic [TAG_W-1:0]         st_tag_i,
   input  logic [REG_W-1:0]         ld_dst_i,
   input  logic [REG_W-1:0]         chk_dst_i,
   output logic [N-1:0]             st_hit_o,
   output logic [N-1:0]             ld_hit_o,
   output logic [N-1:0]             chk_hit_o
);
   // One comparator set per entry, all qualified by the entry being valid
   for (genvar g = 0; g < N; g++) begin : g_cmp
      assign st_hit_o[g]  = valid_i[g] && (tag_i[g] == st_tag_i);
      assign ld_hit_o[g]  = valid_i[g] && (dst_i[g] == ld_dst_i);
      assign chk_hit_o[g] = valid_i[g] && (dst_i[g] == chk_dst_i);
   end
endmodule

// File: rtl/slt_alloc.sv
module slt_alloc #(
   parameter int N = 16
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         clr_i,
   input  logic [N-1:0] busy_i,
   input  logic         take_i,
   output logic [N-1:0] grant_o
);
   localparam int IW = (N > 1) ? $clog2(N) : 1;
   localparam logic [IW-1:0] LAST = IW'(N - 1);

   logic [IW-1:0] rr_q;
   logic [N-1:0]  free_pick;
   logic [N-1:0]  victim;
   logic          full;

   assign full = &busy_i;

   // Lowest-index free slot wins
   always_comb begin
      free_pick = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (!busy_i[i]) begin
            free_pick    = '0;
            free_pick[i] = 1'b1;
         end
      end
   end

   always_comb begin
      victim = '0;
      for (int i = 0; i < N; i++) begin
         if (rr_q == IW'(i)) victim[i] = 1'b1;
      end
   end

   assign grant_o = full ? victim : free_pick;

   always_ff @(posedge clk_i) begin
      if (!rst_ni || clr_i) begin
         rr_q <= '0;
      end else if (take_i && full) begin
         rr_q <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
      end
   end

   // R9: an allocation always lands on exactly one slot
   p_grant_onehot_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      take_i |-> $onehot(grant_o));
   // R9: the victim pointer never leaves the table
   p_ptr_range_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rr_q <= LAST);
endmodule

// File: rtl/spec_load_tracker.sv
module spec_load_tracker
   import slt_pkg::*;
#(
   parameter int ENTRIES  = 16,
   parameter int ADDR_W   = 32,
   parameter int REG_W    = 7,
   parameter int GRAN_LSB = 3
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              flush_i,
   input  logic              ld_valid_i,
   input  logic [ADDR_W-1:0] ld_addr_i,
   input  logic [REG_W-1:0]  ld_dst_i,
   input  logic              ld_fault_i,
   input  logic              st_valid_i,
   input  logic [ADDR_W-1:0] st_addr_i,
   input  logic              chk_valid_i,
   input  logic [REG_W-1:0]  chk_dst_i,
   output logic              chk_done_o,
   output logic              chk_pass_o,
   output logic              recover_o,
   output logic [REG_W-1:0]  recover_dst_o
);
   localparam int TAG_W = ADDR_W - GRAN_LSB;

   // Elaboration-time parameter checks
   if (ENTRIES < 2) begin : g_bad_entries
      $error("spec_load_tracker: ENTRIES must be at least 2");
   end
   if (GRAN_LSB < 0 || GRAN_LSB >= ADDR_W) begin : g_bad_gran
      $error("spec_load_tracker: GRAN_LSB must lie inside the address");
   end
   if (REG_W < 1) begin : g_bad_reg
      $error("spec_load_tracker: REG_W must be positive");
   end

   logic [ENTRIES-1:0]             valid_q, valid_d;
   logic [ENTRIES-1:0]             poison_q, poison_d;
   logic [ENTRIES-1:0][TAG_W-1:0]  tag_q, tag_d;
   logic [ENTRIES-1:0][REG_W-1:0]  dst_q, dst_d;
   logic [TAG_W-1:0]               ld_tag, st_tag;
   logic [ENTRIES-1:0]             st_hit, ld_hit, chk_hit, grant, ld_slot;
   logic                           take;
   chk_res_e                       res_q, res_d;
   logic [REG_W-1:0]               rdst_q;

   // Granule tag extraction; the variant depends on the granule size
   if (GRAN_LSB == 0) begin : g_tag_byte
      assign ld_tag = ld_addr_i;
      assign st_tag = st_addr_i;
   end else begin : g_tag_gran
      logic unused_low;
      assign ld_tag     = ld_addr_i[ADDR_W-1:GRAN_LSB];
      assign st_tag     = st_addr_i[ADDR_W-1:GRAN_LSB];
      assign unused_low = ^{ld_addr_i[GRAN_LSB-1:0], st_addr_i[GRAN_LSB-1:0]};
   end

   slt_match #(.N(ENTRIES), .TAG_W(TAG_W), .REG_W(REG_W)) u_match (
      .valid_i   (valid_q),
      .tag_i     (tag_q),
      .dst_i     (dst_q),
      .st_tag_i  (st_tag),
      .ld_dst_i  (ld_dst_i),
      .chk_dst_i (chk_dst_i),
      .st_hit_o  (st_hit),
      .ld_hit_o  (ld_hit),
      .chk_hit_o (chk_hit)
   );

   // A new slot is needed only when the register is not yet tracked
   assign take    = ld_valid_i && !(|ld_hit) && !flush_i;
   assign ld_slot = (|ld_hit) ? ld_hit : grant;

   slt_alloc #(.N(ENTRIES)) u_alloc (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (flush_i),
      .busy_i  (valid_q),
      .take_i  (take),
      .grant_o (grant)
   );

   // Order inside a cycle: store snoop, check free, load write, flush
   always_comb begin
      valid_d  = valid_q;
      poison_d = poison_q;
      tag_d    = tag_q;
      dst_d    = dst_q;
      if (st_valid_i)  poison_d = poison_q | st_hit;
      if (chk_valid_i) valid_d  = valid_q & ~chk_hit;
      if (ld_valid_i) begin
         for (int i = 0; i < ENTRIES; i++) begin
            if (ld_slot[i]) begin
               valid_d[i]  = 1'b1;
               poison_d[i] = ld_fault_i;
               tag_d[i]    = ld_tag;
               dst_d[i]    = ld_dst_i;
            end
         end
      end
      if (flush_i) begin
         valid_d  = '0;
         poison_d = '0;
      end
   end

   // Check outcome: the same-cycle store is seen, the same-cycle load is not
   always_comb begin
      logic found, bad;
      found = |chk_hit;
      bad   = |(chk_hit & (poison_q | (st_valid_i ? st_hit : '0)));
      if (!chk_valid_i)                res_d = CHK_IDLE;
      else if (flush_i || !found || bad) res_d = CHK_RECOVER;
      else                             res_d = CHK_PASS;
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         valid_q  <= '0;
         poison_q <= '0;
         tag_q    <= '0;
         dst_q    <= '0;
         res_q    <= CHK_IDLE;
         rdst_q   <= '0;
      end else begin
         valid_q  <= valid_d;
         poison_q <= poison_d;
         tag_q    <= tag_d;
         dst_q    <= dst_d;
         res_q    <= res_d;
         rdst_q   <= (res_d == CHK_RECOVER) ? chk_dst_i : '0;
      end
   end

   assign chk_done_o    = (res_q != CHK_IDLE);
   assign chk_pass_o    = (res_q == CHK_PASS);
   assign recover_o     = (res_q == CHK_RECOVER);
   assign recover_dst_o = rdst_q;

   // R1: a flush leaves nothing tracked
   p_flush_empty_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flush_i |=> (valid_q == '0));
   // R12: every check is answered in the next cycle
   p_done_next_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      chk_valid_i |=> chk_done_o);
   // R12: no result without a check in the previous cycle
   p_no_spurious_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !chk_valid_i |=> !chk_done_o);
   // R6: an untracked register always triggers recovery
   p_missing_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (chk_valid_i && !(|chk_hit)) |=> recover_o);
   // R3: a store leaves every entry it hit poisoned or gone
   p_store_poison_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_valid_i && !ld_valid_i && !chk_valid_i && !flush_i)
      |=> (($past(st_hit) & valid_q & ~poison_q) == '0));
   // R8: a register is never tracked by two entries
   p_unique_dst_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ld_valid_i |-> ($countones(ld_hit) <= 1));
endmodule

// File: tb/spec_load_tracker_tb.sv
module spec_load_tracker_tb;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 32;
   localparam int RW = 7;

   localparam logic [1:0] OP_LD = 2'd0, OP_LDF = 2'd1, OP_ST = 2'd2, OP_CHK = 2'd3;
   localparam logic [1:0] EX_NONE = 2'd0, EX_PASS = 2'd1, EX_REC = 2'd2;

   typedef struct packed {
      logic [1:0]    op;
      logic [RW-1:0] rg;
      logic [AW-1:0] ad;
      logic [1:0]    ex;
   } vec_t;

   localparam int NV = 21;
   localparam vec_t VEC [NV] = '{
      '{OP_LD,  7'd5,  32'h1000, EX_NONE},  // R2
      '{OP_CHK, 7'd5,  32'h0,    EX_PASS},  // R2
      '{OP_LD,  7'd6,  32'h2000, EX_NONE},  // R3
      '{OP_ST,  7'd0,  32'h2004, EX_NONE},  // R3 partial overlap
      '{OP_CHK, 7'd6,  32'h0,    EX_REC },  // R3
      '{OP_LD,  7'd7,  32'h3000, EX_NONE},  // R4
      '{OP_ST,  7'd0,  32'h3008, EX_NONE},  // R4 next granule
      '{OP_CHK, 7'd7,  32'h0,    EX_PASS},  // R4
      '{OP_LDF, 7'd8,  32'h4000, EX_NONE},  // R5
      '{OP_CHK, 7'd8,  32'h0,    EX_REC },  // R5
      '{OP_CHK, 7'd9,  32'h0,    EX_REC },  // R6
      '{OP_LD,  7'd10, 32'h5000, EX_NONE},  // R7
      '{OP_CHK, 7'd10, 32'h0,    EX_PASS},  // R7
      '{OP_CHK, 7'd10, 32'h0,    EX_REC },  // R7 freed
      '{OP_LD,  7'd11, 32'h6000, EX_NONE},  // R8
      '{OP_LD,  7'd11, 32'h7000, EX_NONE},  // R8 overwrite
      '{OP_ST,  7'd0,  32'h6000, EX_NONE},  // R8 old address
      '{OP_CHK, 7'd11, 32'h0,    EX_PASS},  // R8
      '{OP_LD,  7'd12, 32'h8000, EX_NONE},  // R8
      '{OP_ST,  7'd0,  32'h8000, EX_NONE},  // R8 poison
      '{OP_LD,  7'd12, 32'h9000, EX_NONE}   // R8 reload clears poison
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          flush = 1'b0;
   logic          ld_v = 1'b0, ld_f = 1'b0, st_v = 1'b0, ck_v = 1'b0;
   logic [AW-1:0] ld_a = '0, st_a = '0;
   logic [RW-1:0] ld_d = '0, ck_d = '0;
   logic          done, pass, rec;
   logic [RW-1:0] rdst;
   int            n_chk = 0;
   int            n_fail = 0;
   bit            finished = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   spec_load_tracker u_dut (
      .clk_i(clk), .rst_ni(rst_n), .flush_i(flush),
      .ld_valid_i(ld_v), .ld_addr_i(ld_a), .ld_dst_i(ld_d), .ld_fault_i(ld_f),
      .st_valid_i(st_v), .st_addr_i(st_a),
      .chk_valid_i(ck_v), .chk_dst_i(ck_d),
      .chk_done_o(done), .chk_pass_o(pass), .recover_o(rec), .recover_dst_o(rdst)
   );

   task automatic idle();
      flush = 1'b0; ld_v = 1'b0; ld_f = 1'b0; st_v = 1'b0; ck_v = 1'b0;
   endtask

   // Called at a falling edge with inputs set; returns at the next falling edge
   task automatic tick();
      @(posedge clk);
      @(negedge clk);
      idle();
   endtask

   task automatic expect_out(input string req, input logic [1:0] ex, input logic [RW-1:0] rg);
      logic [RW+2:0] act, exp;
      act = {done, pass, rec, rdst};
      case (ex)
         EX_PASS: exp = {1'b1, 1'b1, 1'b0, {RW{1'b0}}};
         EX_REC:  exp = {1'b1, 1'b0, 1'b1, rg};
         default: exp = {1'b0, 1'b0, 1'b0, {RW{1'b0}}};
      endcase
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: {done,pass,rec,dst} actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic load(input logic [RW-1:0] rg, input logic [AW-1:0] ad);
      ld_v = 1'b1; ld_d = rg; ld_a = ad; tick();
   endtask

   task automatic check(input string req, input logic [RW-1:0] rg, input logic [1:0] ex);
      ck_v = 1'b1; ck_d = rg; tick(); expect_out(req, ex, rg);
   endtask

   initial begin
      idle();
      repeat (3) @(negedge clk);
      expect_out("R1 reset outputs", EX_NONE, '0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after reset", 7'd5, EX_REC);

      // Vector walk: R2 R3 R4 R5 R6 R7 R8; non-check rows expect no result (R12)
      for (int i = 0; i < NV; i++) begin
         case (VEC[i].op)
            OP_LD:  begin ld_v = 1'b1; ld_d = VEC[i].rg; ld_a = VEC[i].ad; end
            OP_LDF: begin ld_v = 1'b1; ld_f = 1'b1; ld_d = VEC[i].rg; ld_a = VEC[i].ad; end
            OP_ST:  begin st_v = 1'b1; st_a = VEC[i].ad; end
            default: begin ck_v = 1'b1; ck_d = VEC[i].rg; end
         endcase
         tick();
         expect_out($sformatf("vector %0d (R2..R8, R12 idle)", i), VEC[i].ex, VEC[i].rg);
      end
      check("R8 reload clears poison", 7'd12, EX_PASS);

      // R10: store and load to same granule in one cycle
      st_v = 1'b1; st_a = 32'hB000; ld_v = 1'b1; ld_d = 7'd51; ld_a = 32'hB000; tick();
      check("R10 load after same-cycle store", 7'd51, EX_PASS);

      // R11: load and check of same register in one cycle
      ld_v = 1'b1; ld_d = 7'd50; ld_a = 32'hA000; ck_v = 1'b1; ck_d = 7'd50; tick();
      expect_out("R11 check sees old state", EX_REC, 7'd50);
      check("R11 entry kept", 7'd50, EX_PASS);

      // R12: store and check in one cycle
      load(7'd52, 32'hC000);
      st_v = 1'b1; st_a = 32'hC003; ck_v = 1'b1; ck_d = 7'd52; tick();
      expect_out("R12 same-cycle store poisons check", EX_REC, 7'd52);

      // R1: flush
      load(7'd60, 32'hD000);
      flush = 1'b1; tick();
      check("R1 after flush", 7'd60, EX_REC);

      // R9: fill all 16 slots, then displace slot 0
      for (int k = 0; k < 16; k++) load(RW'(20 + k), AW'(32'h10000 + k * 64));
      load(7'd40, 32'h20000);
      check("R9 displaced register", 7'd20, EX_REC);
      check("R9 kept register", 7'd21, EX_PASS);
      check("R9 new register", 7'd40, EX_PASS);
      check("R9 last kept register", 7'd35, EX_PASS);

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule